// File: doc/BRIEF.md
# Four-Lane Pipelined Dot-Product Engine

This block forms the inner product of two signed integer vectors of a fixed length. The default length is 256 elements of 16 bits each. Every accepted input beat carries four consecutive element pairs. The four pairs are multiplied in parallel and the products are captured in a register. A two-level adder tree then folds them into one partial sum, which is registered again. A running accumulator adds that partial sum in. Because each of these steps has its own register, the longest path between flops is a single multiply.

A caller pulses `start` while the engine is idle. It then streams 64 beats through a valid/ready handshake and waits for `done`. The result stays on `result` until the next accepted start. Valid flags move through the pipeline with the data, so idle cycles between beats add nothing to the sum.

Top module: `dotp_engine`

## Requirements
- R1: After reset, `in_ready` and `done` are 0 and `result` is 0.
- R2: A `start` pulse taken while the engine is idle sets `result` to 0 and raises `in_ready` on the next clock edge.
- R3: The final `result` is the sum of A[i]*B[i] over i = 0..255, with both operands signed two's complement. Beat k carries element 4k+j of A in `in_a[16j+15:16j]` and of B in `in_b[16j+15:16j]`, for j = 0..3.
- R4: A beat counts only in a cycle where `in_valid` and `in_ready` are both 1. Operand values driven in other cycles leave the sum unchanged.
- R5: `in_ready` is 0 from the edge that accepts the 64th beat until the next accepted start. While the engine is idle, no more than 64 beats are ever taken.
- R6: `done` is a one-cycle pulse. It rises on the second clock edge after the edge that accepted the last beat, and `result` carries the final sum in that same cycle.
- R7: After `done`, `result` keeps its value until a new start is accepted.
- R8: A `start` pulse that arrives while a computation is in progress is ignored. The beat count and the running sum carry on.
- R9: The accumulator is 42 bits wide and never overflows. This holds even when all 256 products are (-32768)*(-32768) or (-32768)*32767.
- R10: While the engine is idle, `in_valid` and operand values have no effect on `result`, `done` or `in_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new vector; honoured only when idle |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Engine will take a beat this cycle |
| in_a | input | 64 | Four signed 16-bit elements of A, lane 0 in the low bits |
| in_b | input | 64 | Four signed 16-bit elements of B, lane 0 in the low bits |
| result | output | 42 | Signed dot product, held after completion |
| done | output | 1 | One-cycle pulse when `result` is final |

## Verification
The bench drives random operands in stall-free and heavily stalled runs. Random junk is placed on the operand buses during stall cycles. A design that summed on `in_valid` alone, or that let the tree accumulate without its valid flag, would therefore give a wrong total. Directed runs with all operands at -32768, and with -32768 paired against 32767, expose a narrow or unsigned accumulator through a wrapped or wrong-signed result. The bench times `done` to the exact edge after the last beat, so an extra or missing pipeline stage shows up as a pulse in the wrong cycle. A `start` raised partway through a vector catches a design that clears the accumulator mid-run. Pushing `in_valid` while the engine is idle catches a design that leaks beats past the 64th.

// File: rtl/dotp_pkg.sv
// Package: shared sizing for the dot-product engine.
// Assumes lane count is a power of two dividing the vector length.
package dotp_pkg;
    localparam int unsigned DOTP_LANES   = 4;
    localparam int unsigned DOTP_VEC_LEN = 256;
    localparam int unsigned DOTP_DATA_W  = 16;
    localparam int unsigned DOTP_ACC_W   = 2 * DOTP_DATA_W + $clog2(DOTP_VEC_LEN) + 2;
endpackage

// File: rtl/dotp_ctrl.sv
// Module: dotp_ctrl
// Tracks one vector run: accepts start when idle, counts handshake beats,
// flags the final beat and closes the run when the final partial sum lands.
// Assumes drain_end arrives only after the last beat has been taken.
module dotp_ctrl #(
    parameter int unsigned BEATS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic drain_end,
    output logic in_ready,
    output logic clr,
    output logic fire,
    output logic fire_last
);
    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic             running_q;
    logic             all_in_q;
    logic [CNT_W-1:0] beat_cnt_q;

    // Handshake and start qualification.
    always_comb begin
        in_ready  = running_q && !all_in_q;
        fire      = in_valid && in_ready;
        fire_last = fire && (beat_cnt_q == CNT_W'(BEATS - 1));
        clr       = start && !running_q;
    end

    // Run state and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q  <= 1'b0;
            all_in_q   <= 1'b0;
            beat_cnt_q <= '0;
        end else if (clr) begin
            running_q  <= 1'b1;
            all_in_q   <= 1'b0;
            beat_cnt_q <= '0;
        end else begin
            if (fire)      beat_cnt_q <= beat_cnt_q + 1'b1;
            if (fire_last) all_in_q   <= 1'b1;
            if (drain_end) running_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/dotp_mul_stage.sv
// Module: dotp_mul_stage
// One signed multiplier per lane with a product register behind it; a valid
// and a last flag ride along. Assumes lane j sits at bits [j*DATA_W +: DATA_W].
module dotp_mul_stage #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PROD_W = 2 * DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES*DATA_W-1:0]       op_a,
    input  logic [LANES*DATA_W-1:0]       op_b,
    input  logic                          beat_vld,
    input  logic                          beat_last,
    output logic signed [PROD_W-1:0]      prod_q [LANES],
    output logic                          prod_vld_q,
    output logic                          prod_last_q
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic signed [DATA_W-1:0] a_s;
            logic signed [DATA_W-1:0] b_s;
            assign a_s = op_a[g*DATA_W +: DATA_W];
            assign b_s = op_b[g*DATA_W +: DATA_W];

            // Capture this lane's product on an accepted beat.
            always_ff @(posedge clk) begin
                if (!rst_n)        prod_q[g] <= '0;
                else if (beat_vld) prod_q[g] <= a_s * b_s;
            end
        end
    endgenerate

    // Valid and last flags for the product register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_vld_q  <= 1'b0;
            prod_last_q <= 1'b0;
        end else begin
            prod_vld_q  <= beat_vld;
            prod_last_q <= beat_last;
        end
    end
endmodule

// File: rtl/dotp_add_tree.sv
// Module: dotp_add_tree
// Pairwise reduction of LANES products into one registered partial sum.
// Nodes are heap-indexed: leaves at LANES-1.., root at 0. Assumes LANES is a
// power of two so every level pairs cleanly.
module dotp_add_tree #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned PROD_W = 32,
    localparam int unsigned TREE_W = PROD_W + $clog2(LANES),
    localparam int unsigned NODES  = 2 * LANES - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod [LANES],
    input  logic                     prod_vld,
    input  logic                     prod_last,
    output logic signed [TREE_W-1:0] sum_q,
    output logic                     sum_vld_q,
    output logic                     sum_last_q
);
    logic signed [TREE_W-1:0] node [NODES];

    genvar n;
    generate
        for (n = 0; n < NODES; n++) begin : g_node
            if (n >= LANES - 1) begin : g_leaf
                assign node[n] = TREE_W'(prod[n - (LANES - 1)]);
            end else begin : g_add
                assign node[n] = node[2*n+1] + node[2*n+2];
            end
        end
    endgenerate

    // Register the tree root with its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q      <= '0;
            sum_vld_q  <= 1'b0;
            sum_last_q <= 1'b0;
        end else begin
            if (prod_vld) sum_q <= node[0];
            sum_vld_q  <= prod_vld;
            sum_last_q <= prod_last;
        end
    end
endmodule

// File: rtl/dotp_accum.sv
// Module: dotp_accum
// Running-sum register fed back through the final adder; cleared by an
// accepted start, pulses done with the last partial sum. Assumes the
// pipeline is empty whenever clr is raised.
module dotp_accum #(
    parameter int unsigned TREE_W = 34,
    parameter int unsigned ACC_W  = 42
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic signed [TREE_W-1:0] part,
    input  logic                     part_vld,
    input  logic                     part_last,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic                     done_q
);
    logic signed [ACC_W-1:0] part_ext;

    // Sign-extend the partial sum to accumulator width.
    always_comb part_ext = {{(ACC_W-TREE_W){part[TREE_W-1]}}, part};

    // Accumulate valid partial sums and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (clr)           acc_q <= '0;
            else if (part_vld) acc_q <= acc_q + part_ext;
            done_q <= part_vld && part_last;
        end
    end
endmodule

// File: rtl/dotp_engine.sv
// Module: dotp_engine (top)
// Four-lane signed dot product over a fixed-length vector: multiply,
// tree-reduce and accumulate in three registered stages. Assumes the
// caller waits for done before starting the next vector.
module dotp_engine
    import dotp_pkg::*;
#(
    parameter int unsigned LANES   = DOTP_LANES,
    parameter int unsigned VEC_LEN = DOTP_VEC_LEN,
    parameter int unsigned DATA_W  = DOTP_DATA_W,
    parameter int unsigned ACC_W   = DOTP_ACC_W,
    localparam int unsigned BEATS  = VEC_LEN / LANES,
    localparam int unsigned PROD_W = 2 * DATA_W,
    localparam int unsigned TREE_W = PROD_W + $clog2(LANES),
    localparam int unsigned BUS_W  = LANES * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [BUS_W-1:0]        in_a,
    input  logic [BUS_W-1:0]        in_b,
    output logic signed [ACC_W-1:0] result,
    output logic                    done
);
    logic clr, fire, fire_last;
    logic signed [PROD_W-1:0] prod [LANES];
    logic prod_vld, prod_last;
    logic signed [TREE_W-1:0] part;
    logic part_vld, part_last;

    dotp_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .drain_end (part_vld && part_last),
        .in_ready  (in_ready),
        .clr       (clr),
        .fire      (fire),
        .fire_last (fire_last)
    );

    dotp_mul_stage #(.LANES(LANES), .DATA_W(DATA_W)) u_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_a        (in_a),
        .op_b        (in_b),
        .beat_vld    (fire),
        .beat_last   (fire_last),
        .prod_q      (prod),
        .prod_vld_q  (prod_vld),
        .prod_last_q (prod_last)
    );

    dotp_add_tree #(.LANES(LANES), .PROD_W(PROD_W)) u_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod       (prod),
        .prod_vld   (prod_vld),
        .prod_last  (prod_last),
        .sum_q      (part),
        .sum_vld_q  (part_vld),
        .sum_last_q (part_last)
    );

    dotp_accum #(.TREE_W(TREE_W), .ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .part      (part),
        .part_vld  (part_vld),
        .part_last (part_last),
        .acc_q     (result),
        .done_q    (done)
    );
endmodule

// File: rtl/dotp_engine_chk.sv
// Module: dotp_engine_chk
// Protocol checker bound to dotp_engine; keeps its own idle flag and beat
// count from the ports only.
module dotp_engine_chk #(
    parameter int unsigned BEATS = 64,
    parameter int unsigned ACC_W = 42
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ACC_W-1:0] result,
    input logic             done
);
    localparam int unsigned BCNT_W = $clog2(BEATS) + 2;

    logic              idle_q;
    logic [BCNT_W-1:0] beats_q;

    // Independent model of idle state and beats taken in this run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= 1'b1;
            beats_q <= '0;
        end else if (idle_q && start) begin
            idle_q  <= 1'b0;
            beats_q <= '0;
        end else begin
            if (in_valid && in_ready) beats_q <= beats_q + 1'b1;
            if (done) idle_q <= 1'b1;
        end
    end

    AST_READY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q && start |=> in_ready);                         // R2
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q && start |=> result == '0);                      // R2
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        beats_q <= BCNT_W'(BEATS));                             // R5
    AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> !in_ready);                                  // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                        // R6
    AST_DONE_ALL_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beats_q == BCNT_W'(BEATS));                    // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q && !start |=> $stable(result));                  // R7
endmodule

bind dotp_engine dotp_engine_chk #(.BEATS(BEATS), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .result   (result),
    .done     (done)
);

// File: tb/dotp_engine_test.sv
// Bench for dotp_engine: random and directed vectors, cycle-exact done check.
module dotp_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int VLEN = 256;
    localparam int DW = 16;
    localparam int AW = 42;
    localparam int NBEATS = VLEN / LANES;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [LANES*DW-1:0] in_a = '0;
    logic [LANES*DW-1:0] in_b = '0;
    logic signed [AW-1:0] result;
    logic done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int va [VLEN];
    int vb [VLEN];

    dotp_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .result(result), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expected_sum();
        longint s = 0;
        for (int i = 0; i < VLEN; i++) s += longint'(va[i]) * longint'(vb[i]);
        return s;
    endfunction

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    // Drive one full vector; stall_pct = chance of an idle cycle.
    task automatic run_vec(input int stall_pct, input bit mid_start, input string tag);
        longint exp = expected_sum();
        int k = 0;
        bit f;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(in_ready == 1'b1, {"R2 ready ", tag}, in_ready, 1);
        chk(result == '0, {"R2 clear ", tag}, result, 0);
        while (k < NBEATS) begin
            in_valid = (($urandom % 100) >= stall_pct);
            for (int j = 0; j < LANES; j++) begin
                in_a[j*DW +: DW] = in_valid ? DW'(va[4*k+j]) : DW'($urandom);
                in_b[j*DW +: DW] = in_valid ? DW'(vb[4*k+j]) : DW'($urandom);
            end
            start = mid_start && (k == 20);
            f = in_valid && in_ready;
            @(negedge clk);
            if (f) k++;
        end
        in_valid = 1'b0;
        start = 1'b0;
        chk(in_ready == 1'b0, {"R5 ready low ", tag}, in_ready, 0);
        chk(done == 1'b0, {"R6 early1 ", tag}, done, 0);
        @(negedge clk);
        chk(done == 1'b0, {"R6 early2 ", tag}, done, 0);
        @(negedge clk);
        chk(done == 1'b1, {"R6 pulse ", tag}, done, 1);
        chk(longint'(result) == exp, {"R3 R4 R8 R9 sum ", tag}, result, exp);
        @(negedge clk);
        chk(done == 1'b0, {"R6 one cycle ", tag}, done, 0);
        chk(longint'(result) == exp, {"R7 hold ", tag}, result, exp);
    endtask

    initial begin
        longint held;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 ready", in_ready, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(result == '0, "R1 result", result, 0);

        for (int i = 0; i < VLEN; i++) begin va[i] = rnd16(); vb[i] = rnd16(); end
        run_vec(0, 1'b0, "random no stall");

        // R10: idle, valid with junk data must change nothing
        held = longint'(result);
        in_valid = 1'b1;
        for (int c = 0; c < 6; c++) begin
            in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
            @(negedge clk);
            chk(in_ready == 1'b0 && done == 1'b0, "R10 idle ready/done", in_ready, 0);
            chk(longint'(result) == held, "R10 idle result", result, held);
        end
        in_valid = 1'b0;

        for (int i = 0; i < VLEN; i++) begin va[i] = rnd16(); vb[i] = rnd16(); end
        run_vec(60, 1'b0, "random stalls");

        for (int i = 0; i < VLEN; i++) begin va[i] = rnd16(); vb[i] = rnd16(); end
        run_vec(30, 1'b1, "R8 mid start");

        for (int i = 0; i < VLEN; i++) begin va[i] = -32768; vb[i] = -32768; end
        run_vec(10, 1'b0, "R9 max positive");

        for (int i = 0; i < VLEN; i++) begin va[i] = -32768; vb[i] = 32767; end
        run_vec(0, 1'b0, "R9 max negative");

        for (int i = 0; i < VLEN; i++) begin va[i] = (i % 2) ? 1 : -1; vb[i] = i; end
        run_vec(20, 1'b0, "alternating signs");

        report();
    end
endmodule